// File: doc/BRIEF.md
# Shared Queue-Status Bus Multiplexer

This block places the per-queue status flags of sixteen queues onto an eight-bit status bus. The bus carries one group of eight queues, called a sector, at a time. Sector 0 holds queues 0 to 7 and sector 1 holds queues 8 to 15. The flags themselves are produced elsewhere and arrive as a sixteen-bit input vector. A separate queue-count input gives the number of configured queues.

A mode input is sampled while reset is held. When it is low, the block works in direct mode. A strobe and an address pick the sector, and the device owns the bus only when the upper address bits match its static device ID. When the mode input is high, the block works in polled mode. The block then steps through its two sectors on its own and hands bus ownership to the next device over a token ring. The device marked as master starts the ring after reset. A sync output marks the cycle in which sector 0 is on the bus. A bus-enable output stands in for a tri-state driver, and the bus reads zero whenever that enable is low.

The control is one state machine with four states:
- ST_DIRECT: the state for direct mode; the machine stays in it.
- ST_IDLE: polled mode without the token.
- ST_SECT0: polled mode, driving sector 0.
- ST_SECT1: polled mode, driving sector 1.

Reset enters ST_DIRECT or ST_IDLE, depending on the mode input. The transitions are:
- ST_IDLE goes to ST_SECT0 when a pending master start or token_in is present.
- ST_SECT0 always goes to ST_SECT1.
- ST_SECT1 goes to ST_SECT0 if token_in is high, and otherwise to ST_IDLE.

Top module: `qsb_bus_mux`

## Requirements
- R1: The mode input is sampled during reset. Low selects direct mode and high selects polled mode. In direct mode after reset, the bus is enabled only on the master device, with sector 0 selected, and sync and token_out are 0.
- R2: In direct mode, suppose a clock edge has strobe high, queue_sel low, and addr[4:2] equal to dev_id. In the following cycle bus_en is 1, and the bus shows the sector given by addr[0].
- R3: In direct mode, a strobe with queue_sel low and addr[4:2] different from dev_id drops bus_en to 0 in the following cycle.
- R4: A strobe that arrives in the same cycle as queue_sel is ignored, and both the sector and bus ownership stay unchanged.
- R5: Bus bit b carries queue b in sector 0 and queue 8+b in sector 1. A bit whose queue index is at or above q_count reads 0.
- R6: When q_count is 8 or less, the bus always shows queues 0 to 7, whatever sector is selected or polled.
- R7: In polled mode, the master drives sector 0 in the first cycle after the first clock edge with reset released. The sector then advances on every edge.
- R8: sync is 1 exactly in the cycles when sector 0 is on the bus in polled mode, and it is 0 in direct mode.
- R9: token_out is 1 during the sector 1 cycle. If token_in is 0 at the end of that cycle, the bus is disabled next. If token_in is 1, sector 0 follows, which is the single-device loop.
- R10: A polled device without the token keeps bus_en at 0. When it samples token_in high, it drives sector 0 in the following cycle.
- R11: Whenever bus_en is 0, the bus reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Mode select, sampled during reset (0 direct, 1 polled) |
| is_master | input | 1 | Static: this device starts first / owns the bus after reset |
| dev_id | input | 3 | Static device ID |
| q_count | input | 5 | Number of configured queues (0 to 16) |
| q_status | input | 16 | Per-queue status flags |
| strobe | input | 1 | Sector-select strobe (direct mode) |
| queue_sel | input | 1 | Queue selection in this cycle; blocks the strobe |
| addr | input | 5 | [4:2] device ID, [0] sector |
| token_in | input | 1 | Ring token from the previous device |
| bus | output | 8 | Status bus |
| bus_en | output | 1 | Bus drive enable |
| sync | output | 1 | High while sector 0 is on the bus (polled) |
| token_out | output | 1 | Ring token to the next device |

## Verification
The bench probes the following corner cases:
- A strobe that collides with a queue selection. A design that let the strobe win would switch sector.
- A strobe carrying a foreign device ID. A design that ignored the ID would keep or steal the bus.
- A queue count of 10. Sector 1 must then show only two live bits, and a wrong mask would leak the status of unconfigured queues.
- A queue count of 6. A design that honoured the selected sector would show the upper queues.
- In polled mode, the first cycle after reset release, which catches an off-by-one start.
- Token hand-off in both directions. A late or missing token_out would stall the ring or leave two devices driving.

// File: rtl/qsb_pkg.sv
package qsb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIRECT = 2'd1,
        ST_SECT0  = 2'd2,
        ST_SECT1  = 2'd3
    } ring_state_t;
endpackage

// File: rtl/qsb_dir_sel.sv
module qsb_dir_sel #(
    parameter int ADDR_W = 5,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic [ID_W-1:0]   dev_id,
    input  logic              active,
    input  logic              strobe,
    input  logic              queue_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              own,
    output logic              sector
);
    localparam int ID_LSB = ADDR_W - ID_W;

    logic id_hit;
    assign id_hit = (addr[ADDR_W-1:ID_LSB] == dev_id);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own    <= is_master;
            sector <= 1'b0;
        end else if (active && strobe && !queue_sel) begin
            own <= id_hit;
            if (id_hit) begin
                sector <= addr[0];
            end
        end
    end
endmodule

// File: rtl/qsb_ring_fsm.sv
module qsb_ring_fsm
    import qsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic is_master,
    input  logic token_in,
    output logic is_direct,
    output logic ring_en,
    output logic ring_sec,
    output logic sync,
    output logic token_out
);
    ring_state_t state, state_nx;
    logic        start_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= mode_sel ? ST_IDLE : ST_DIRECT;
            start_pend <= mode_sel & is_master;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && state_nx == ST_SECT0) begin
                start_pend <= 1'b0;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DIRECT: state_nx = ST_DIRECT;
            ST_IDLE:   state_nx = (start_pend || token_in) ? ST_SECT0 : ST_IDLE;
            ST_SECT0:  state_nx = ST_SECT1;
            ST_SECT1:  state_nx = token_in ? ST_SECT0 : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        is_direct = 1'b0;
        ring_en   = 1'b0;
        ring_sec  = 1'b0;
        sync      = 1'b0;
        token_out = 1'b0;
        unique case (state)
            ST_DIRECT: is_direct = 1'b1;
            ST_IDLE:   ;
            ST_SECT0: begin
                ring_en = 1'b1;
                sync    = 1'b1;
            end
            ST_SECT1: begin
                ring_en   = 1'b1;
                ring_sec  = 1'b1;
                token_out = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qsb_sector_view.sv
module qsb_sector_view #(
    parameter int BUS_W = 8,
    parameter int NUM_Q = 16,
    parameter int CNT_W = 5
) (
    input  logic [NUM_Q-1:0] q_status,
    input  logic [CNT_W-1:0] q_count,
    input  logic             sector,
    input  logic             enable,
    output logic [BUS_W-1:0] bus
);
    logic narrow;
    logic use_hi;
    assign narrow = (q_count <= CNT_W'(BUS_W));
    assign use_hi = sector & ~narrow;

    for (genvar b = 0; b < BUS_W; b++) begin : g_bit
        localparam int LO = b;
        localparam int HI = BUS_W + b;
        logic lo_live, hi_live;
        assign lo_live = q_status[LO] & (CNT_W'(LO) < q_count);
        assign hi_live = q_status[HI] & (CNT_W'(HI) < q_count);
        assign bus[b]  = enable & (use_hi ? hi_live : lo_live);
    end
endmodule

// File: rtl/qsb_bus_mux.sv
module qsb_bus_mux #(
    parameter int BUS_W  = 8,
    parameter int ID_W   = 3,
    parameter int ADDR_W = 5,
    localparam int NUM_Q = 2 * BUS_W,
    localparam int CNT_W = $clog2(NUM_Q + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              is_master,
    input  logic [ID_W-1:0]   dev_id,
    input  logic [CNT_W-1:0]  q_count,
    input  logic [NUM_Q-1:0]  q_status,
    input  logic              strobe,
    input  logic              queue_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              token_in,
    output logic [BUS_W-1:0]  bus,
    output logic              bus_en,
    output logic              sync,
    output logic              token_out
);
    logic is_direct, ring_en, ring_sec;
    logic dir_own, dir_sec, cur_sec;

    qsb_ring_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .is_master (is_master),
        .token_in  (token_in),
        .is_direct (is_direct),
        .ring_en   (ring_en),
        .ring_sec  (ring_sec),
        .sync      (sync),
        .token_out (token_out)
    );

    qsb_dir_sel #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_master (is_master),
        .dev_id    (dev_id),
        .active    (is_direct),
        .strobe    (strobe),
        .queue_sel (queue_sel),
        .addr      (addr),
        .own       (dir_own),
        .sector    (dir_sec)
    );

    assign bus_en  = is_direct ? dir_own : ring_en;
    assign cur_sec = is_direct ? dir_sec : ring_sec;

    qsb_sector_view #(.BUS_W(BUS_W), .NUM_Q(NUM_Q), .CNT_W(CNT_W)) u_view (
        .q_status (q_status),
        .q_count  (q_count),
        .sector   (cur_sec),
        .enable   (bus_en),
        .bus      (bus)
    );
endmodule

// File: rtl/qsb_bus_mux_chk.sv
module qsb_bus_mux_chk #(
    parameter int BUS_W  = 8,
    parameter int ID_W   = 3,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   dev_id,
    input logic              strobe,
    input logic              queue_sel,
    input logic [ADDR_W-1:0] addr,
    input logic              token_in,
    input logic [BUS_W-1:0]  bus,
    input logic              bus_en,
    input logic              sync,
    input logic              token_out,
    input logic              is_direct
);
    localparam int ID_LSB = ADDR_W - ID_W;

    p_id_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_direct && strobe && !queue_sel && addr[ADDR_W-1:ID_LSB] == dev_id) |=> bus_en);

    p_id_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_direct && strobe && !queue_sel && addr[ADDR_W-1:ID_LSB] != dev_id) |=> !bus_en);

    p_qsel_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_direct && strobe && queue_sel) |=> $stable(bus_en));

    p_sector_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (bus_en && !sync));

    p_sync_polled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync |-> (bus_en && !is_direct && !token_out));

    p_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (token_out && !token_in) |=> !bus_en);

    p_token_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_direct && !bus_en && token_in) |=> sync);

    p_quiet_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (bus == '0));
endmodule

bind qsb_bus_mux qsb_bus_mux_chk #(.BUS_W(BUS_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_id    (dev_id),
    .strobe    (strobe),
    .queue_sel (queue_sel),
    .addr      (addr),
    .token_in  (token_in),
    .bus       (bus),
    .bus_en    (bus_en),
    .sync      (sync),
    .token_out (token_out),
    .is_direct (is_direct)
);

// File: tb/qsb_bus_mux_bench.sv
module qsb_bus_mux_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0;
    logic        is_master = 1'b0;
    logic [2:0]  dev_id = 3'd5;
    logic [4:0]  q_count = 5'd16;
    logic [15:0] q_status = 16'h0000;
    logic        strobe = 1'b0;
    logic        queue_sel = 1'b0;
    logic [4:0]  addr = 5'd0;
    logic        tok_loop = 1'b0;
    logic        tok_drv = 1'b0;
    logic        token_in;
    logic [7:0]  bus;
    logic        bus_en, sync, token_out;

    assign token_in = tok_loop ? token_out : tok_drv;

    qsb_bus_mux u_qsb_bus_mux (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .is_master(is_master),
        .dev_id(dev_id), .q_count(q_count), .q_status(q_status),
        .strobe(strobe), .queue_sel(queue_sel), .addr(addr),
        .token_in(token_in), .bus(bus), .bus_en(bus_en), .sync(sync),
        .token_out(token_out)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    bit m_valid = 1'b0;
    bit m_mode, m_own, m_sec, m_pend;
    int m_phase;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_en();
        return m_mode ? (m_phase != 0) : m_own;
    endfunction

    function automatic logic [7:0] exp_bus();
        logic [7:0] r = '0;
        int sec = m_mode ? ((m_phase == 2) ? 1 : 0) : int'(m_sec);
        if (q_count <= 8) sec = 0;
        if (exp_en()) begin
            for (int b = 0; b < 8; b++) begin
                int idx = sec * 8 + b;
                r[b] = (idx < int'(q_count)) ? q_status[idx] : 1'b0;
            end
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode  = mode_sel;
            m_own   = is_master;
            m_sec   = 1'b0;
            m_phase = 0;
            m_pend  = is_master && mode_sel;
            m_valid = 1'b1;
        end else if (!m_mode) begin
            if (strobe && !queue_sel) begin
                if (addr[4:2] == dev_id) begin
                    m_own = 1'b1;
                    m_sec = addr[0];
                end else begin
                    m_own = 1'b0;
                end
            end
        end else begin
            case (m_phase)
                0: if (m_pend || token_in) begin m_phase = 1; m_pend = 1'b0; end
                1: m_phase = 2;
                default: m_phase = token_in ? 1 : 0;
            endcase
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (m_valid && !done) begin
            chk("R5 bus", {24'd0, bus}, {24'd0, exp_bus()});
            chk("R2 bus_en", {31'd0, bus_en}, {31'd0, exp_en()});
            chk("R8 sync", {31'd0, sync}, {31'd0, m_mode && m_phase == 1});
            chk("R9 token_out", {31'd0, token_out}, {31'd0, m_mode && m_phase == 2});
        end
    end

    task automatic do_reset(input bit md, input bit mst, input logic [4:0] qc);
        @(posedge clk); #5;
        rst_n = 1'b0; mode_sel = md; is_master = mst; q_count = qc;
        strobe = 1'b0; queue_sel = 1'b0;
        repeat (2) @(posedge clk);
        #5 rst_n = 1'b1;
    endtask

    task automatic sel(input logic [4:0] a, input bit qs);
        @(posedge clk); #5;
        strobe = 1'b1; addr = a; queue_sel = qs;
        @(posedge clk); #5;
        strobe = 1'b0; queue_sel = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic set_status(input logic [15:0] s);
        @(posedge clk); #5 q_status = s;
        @(negedge clk); #1;
    endtask

    initial begin
        // direct mode, non-master, ID 5, 16 queues
        q_status = 16'hA55A;
        do_reset(1'b0, 1'b0, 5'd16);
        @(negedge clk); #1;
        chk("R1 direct reset bus_en", {31'd0, bus_en}, 32'd0);
        chk("R1 direct reset sync", {31'd0, sync}, 32'd0);
        chk("R11 idle bus zero", {24'd0, bus}, 32'd0);

        sel({3'd5, 1'b0, 1'b1}, 1'b0);
        chk("R2 take bus_en", {31'd0, bus_en}, 32'd1);
        chk("R2 sector 1 shown", {24'd0, bus}, 32'hA5);
        set_status(16'h3C81);
        chk("R5 sector 1 mapping", {24'd0, bus}, 32'h3C);
        sel({3'd5, 1'b0, 1'b0}, 1'b0);
        chk("R5 sector 0 mapping", {24'd0, bus}, 32'h81);
        sel({3'd5, 1'b0, 1'b1}, 1'b1);
        chk("R4 qsel blocks sector change", {24'd0, bus}, 32'h81);
        sel({3'd2, 1'b0, 1'b1}, 1'b0);
        chk("R3 foreign ID drops bus", {31'd0, bus_en}, 32'd0);
        chk("R11 dropped bus zero", {24'd0, bus}, 32'd0);
        sel({3'd5, 1'b0, 1'b1}, 1'b1);
        chk("R4 qsel blocks ownership", {31'd0, bus_en}, 32'd0);
        sel({3'd5, 1'b0, 1'b1}, 1'b0);
        sel({3'd3, 1'b0, 1'b0}, 1'b1);
        chk("R4 qsel keeps ownership", {31'd0, bus_en}, 32'd1);
        chk("R4 qsel keeps sector", {24'd0, bus}, 32'h3C);
        // back-to-back strobes every cycle
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #5;
            strobe = 1'b1; addr = {3'd5, 1'b0, i[0]};
        end
        @(posedge clk); #5 strobe = 1'b0;

        // direct, master, 10 queues
        q_status = 16'hFFFF;
        do_reset(1'b0, 1'b1, 5'd10);
        @(negedge clk); #1;
        chk("R1 master owns after reset", {31'd0, bus_en}, 32'd1);
        sel({3'd5, 1'b0, 1'b1}, 1'b0);
        chk("R5 unconfigured bits zero", {24'd0, bus}, 32'h03);

        // direct, 6 queues: sector choice has no effect
        do_reset(1'b0, 1'b1, 5'd6);
        sel({3'd5, 1'b0, 1'b1}, 1'b0);
        chk("R6 narrow ignores sector", {24'd0, bus}, 32'h3F);

        // polled master, single-device loop
        q_status = 16'h12EF;
        tok_loop = 1'b1;
        do_reset(1'b1, 1'b1, 5'd16);
        @(negedge clk); #1;
        chk("R10 idle before first edge", {31'd0, bus_en}, 32'd0);
        @(negedge clk); #1;
        chk("R7 master starts sector 0", {31'd0, sync}, 32'd1);
        chk("R7 sector 0 data", {24'd0, bus}, 32'hEF);
        @(negedge clk); #1;
        chk("R7 advances to sector 1", {24'd0, bus}, 32'h12);
        chk("R9 token_out in sector 1", {31'd0, token_out}, 32'd1);
        @(negedge clk); #1;
        chk("R9 loop returns to sector 0", {31'd0, sync}, 32'd1);
        repeat (10) @(posedge clk);

        // polled non-master, token from outside
        tok_loop = 1'b0; tok_drv = 1'b0;
        do_reset(1'b1, 1'b0, 5'd16);
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
        chk("R10 no token no drive", {31'd0, bus_en}, 32'd0);
        @(posedge clk); #5 tok_drv = 1'b1;
        @(posedge clk); #5 tok_drv = 1'b0;
        @(negedge clk); #1;
        chk("R10 token starts sector 0", {31'd0, sync}, 32'd1);
        @(negedge clk); #1;
        chk("R9 token passed on", {31'd0, token_out}, 32'd1);
        @(negedge clk); #1;
        chk("R9 released after hand-off", {31'd0, bus_en}, 32'd0);

        // polled master, 8 queues: both slots show queues 0-7
        tok_loop = 1'b1;
        do_reset(1'b1, 1'b1, 5'd8);
        @(negedge clk); #1;
        @(negedge clk); #1;
        @(negedge clk); #1;
        chk("R6 polled narrow sector 1", {24'd0, bus}, 32'hEF);
        repeat (6) @(posedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule